// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port memory and decides what happens when both ports reach for the same word at once. Each side, called left and right, presents an enable, a word address and a write strobe every clock. A collision exists only while both sides are enabled on the same address. The arbiter then lets one side keep the word, raises a busy flag toward the other, and removes the other side's write permit. A read from the losing side still goes ahead, but it is marked as carrying data that cannot be relied on.

A mode input sets the block's role when several memories are placed side by side to build a wider word. In the deciding role the block resolves collisions itself and sends its busy flags out. In the following role it resolves nothing: it takes busy flags from the deciding device and uses them only to hold back writes. A following write may start only once the incoming busy flag has been low for two clock edges in a row.

The side whose enable and address were already in place on the previous clock edge wins. If both arrive on the same edge, the left side wins.

Top module: `dp_collision_arbiter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, both busy outputs are low.
- R2: A collision needs both enables high and the two addresses equal. In any other cycle, both busy outputs are low on the next clock, and each side's write permit equals its enable AND its write strobe.
- R3: In deciding mode, if one side's enable and address were already held on the previous edge and the other side has just arrived at the same address, the held side wins. Busy toward the newcomer goes high one clock later.
- R4: In deciding mode, if both sides arrive at the same address in the same cycle, the left side wins: busy_right_o goes high and busy_left_o stays low.
- R5: While the collision persists, the winner stays the winner, even after both sides have held their addresses for several cycles.
- R6: Busy clears one clock after the addresses differ or after either enable goes low.
- R7: In deciding mode, the losing side's write permit is low in the same cycle in which the collision is seen, including the cycle in which it first appears.
- R8: A losing side that is enabled with its write strobe low (a read) drives its read-unsure flag high. That flag is low whenever the side is writing or is not losing.
- R9: In following mode, a side's write permit is low while its busy input is high and for one further cycle after the input falls.
- R10: In following mode, both busy outputs stay low even when the addresses collide. In deciding mode, the busy inputs have no effect.
- R11: The two busy outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = deciding role, 0 = following role |
| left_en | input | 1 | Left side enable |
| left_addr | input | ADDR_W | Left side word address |
| left_we | input | 1 | Left side write strobe (1 = write, 0 = read) |
| right_en | input | 1 | Right side enable |
| right_addr | input | ADDR_W | Right side word address |
| right_we | input | 1 | Right side write strobe |
| busy_in_left | input | 1 | External busy toward left, used in following mode |
| busy_in_right | input | 1 | External busy toward right, used in following mode |
| busy_left_o | output | 1 | Registered busy toward left, driven in deciding mode |
| busy_right_o | output | 1 | Registered busy toward right, driven in deciding mode |
| left_wr_ok | output | 1 | Write permit to the array for left |
| right_wr_ok | output | 1 | Write permit to the array for right |
| left_rd_unsure | output | 1 | Left read data not guaranteed |
| right_rd_unsure | output | 1 | Right read data not guaranteed |

## Verification
The properties assume that the mode input changes only between whole access cycles. The ownership rule in particular assumes that mode stays steady while a collision is being held. The stimulus changes mode only at points where no collision is in progress. The properties also treat a side's arrival purely as its enable and address being equal on two consecutive edges. To exercise every path, the bench steps the sides onto matching addresses in a chosen order: left held first, right held first, and both on the same edge. Busy inputs are driven only in following mode, except for one deliberate check that deciding mode ignores them.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   busy_l;
        logic   busy_r;
    } arb_state_t;

    localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/dpa_side_track.sv
// Remembers one side's enable, address and external busy from the previous
// edge, so that arrival order and busy settling can be judged.
module dpa_side_track #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_ext_i,
    output logic              held_o,
    output logic              busy_ext_q_o
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic              busy_ext;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d          = trk_q;
        trk_d.en       = en_i;
        trk_d.addr     = addr_i;
        trk_d.busy_ext = busy_ext_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // A side counts as "held" when it was already enabled on the same word
    // at the previous edge.
    assign held_o       = en_i && trk_q.en && (addr_i == trk_q.addr);
    assign busy_ext_q_o = trk_q.busy_ext;
endmodule

// File: rtl/dpa_owner.sv
// Holds which side owns a contended word and registers the busy flags.
module dpa_owner (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_i,
    input  logic            match_i,
    input  logic            left_held_i,
    input  logic            right_held_i,
    output dpa_pkg::owner_e owner_now_o,
    output logic            busy_l_o,
    output logic            busy_r_o
);
    import dpa_pkg::*;

    arb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!master_i || !match_i) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            // Newly seen collision: the side already in place wins; a tie
            // (both new or both held) goes to the left side.
            if (right_held_i && !left_held_i) begin
                st_d.owner = OWN_RIGHT;
            end else begin
                st_d.owner = OWN_LEFT;
            end
        end
        st_d.busy_l = (st_d.owner == OWN_RIGHT);
        st_d.busy_r = (st_d.owner == OWN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, busy_l: 1'b0, busy_r: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_now_o = st_d.owner;
    assign busy_l_o    = st_q.busy_l;
    assign busy_r_o    = st_q.busy_r;
endmodule

// File: rtl/dpa_side_gate.sv
// Turns one side's access into a write permit and a read-unsure flag.
module dpa_side_gate (
    input  logic master_i,
    input  logic en_i,
    input  logic we_i,
    input  logic lose_i,
    input  logic busy_ext_i,
    input  logic busy_ext_q_i,
    output logic wr_ok_o,
    output logic rd_unsure_o
);
    logic blocked;

    always_comb begin
        if (master_i) begin
            blocked = lose_i;
        end else begin
            // Following role: the busy input must have been low at this
            // edge and at the previous one.
            blocked = busy_ext_i || busy_ext_q_i;
        end
        wr_ok_o     = en_i && we_i && !blocked;
        rd_unsure_o = en_i && !we_i && blocked;
    end
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter #(
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              left_en,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              left_we,
    input  logic              right_en,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              right_we,
    input  logic              busy_in_left,
    input  logic              busy_in_right,
    output logic              busy_left_o,
    output logic              busy_right_o,
    output logic              left_wr_ok,
    output logic              right_wr_ok,
    output logic              left_rd_unsure,
    output logic              right_rd_unsure
);
    import dpa_pkg::*;

    localparam int unsigned NS = NUM_SIDES;

    logic [NS-1:0]     en_v, we_v, bin_v, held_v, binq_v, lose_v, wr_v, un_v;
    logic [ADDR_W-1:0] addr_v [NS];
    owner_e            owner_now;
    logic              match;

    assign en_v   = {right_en, left_en};
    assign we_v   = {right_we, left_we};
    assign bin_v  = {busy_in_right, busy_in_left};
    assign addr_v[0] = left_addr;
    assign addr_v[1] = right_addr;

    assign match = en_v[0] && en_v[1] && (addr_v[0] == addr_v[1]);

    for (genvar p = 0; p < NS; p++) begin : g_side
        dpa_side_track #(.ADDR_W(ADDR_W)) u_track (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (en_v[p]),
            .addr_i       (addr_v[p]),
            .busy_ext_i   (bin_v[p]),
            .held_o       (held_v[p]),
            .busy_ext_q_o (binq_v[p])
        );

        assign lose_v[p] = (owner_now == ((p == 0) ? OWN_RIGHT : OWN_LEFT));

        dpa_side_gate u_gate (
            .master_i     (master_mode),
            .en_i         (en_v[p]),
            .we_i         (we_v[p]),
            .lose_i       (lose_v[p]),
            .busy_ext_i   (bin_v[p]),
            .busy_ext_q_i (binq_v[p]),
            .wr_ok_o      (wr_v[p]),
            .rd_unsure_o  (un_v[p])
        );
    end

    dpa_owner u_owner (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_i     (master_mode),
        .match_i      (match),
        .left_held_i  (held_v[0]),
        .right_held_i (held_v[1]),
        .owner_now_o  (owner_now),
        .busy_l_o     (busy_left_o),
        .busy_r_o     (busy_right_o)
    );

    assign left_wr_ok      = wr_v[0];
    assign right_wr_ok     = wr_v[1];
    assign left_rd_unsure  = un_v[0];
    assign right_rd_unsure = un_v[1];
endmodule

// File: rtl/dp_collision_arbiter_chk.sv
module dp_collision_arbiter_chk #(
    parameter int unsigned ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              left_en,
    input logic [ADDR_W-1:0] left_addr,
    input logic              left_we,
    input logic              right_en,
    input logic [ADDR_W-1:0] right_addr,
    input logic              busy_in_left,
    input logic              busy_left_o,
    input logic              busy_right_o,
    input logic              left_wr_ok
);
    logic hit;
    assign hit = left_en && right_en && (left_addr == right_addr);

    // R11
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_left_o && busy_right_o));

    // R2
    no_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (!busy_left_o && !busy_right_o));

    // R5
    keep_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && busy_right_o && hit) |=> busy_right_o);

    // R7
    loser_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && busy_left_o && hit) |-> !left_wr_ok);

    // R9
    slave_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && busy_in_left) |=> (master_mode || !left_wr_ok));

    // R10
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |=> (!busy_left_o && !busy_right_o));

    // R2
    wr_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_wr_ok |-> (left_en && left_we));
endmodule

bind dp_collision_arbiter dp_collision_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_mode  (master_mode),
    .left_en      (left_en),
    .left_addr    (left_addr),
    .left_we      (left_we),
    .right_en     (right_en),
    .right_addr   (right_addr),
    .busy_in_left (busy_in_left),
    .busy_left_o  (busy_left_o),
    .busy_right_o (busy_right_o),
    .left_wr_ok   (left_wr_ok)
);

// File: tb/dp_collision_arbiter_tb.sv
module dp_collision_arbiter_tb;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms = 1'b1;
    logic le = 1'b0, lwe = 1'b0, re = 1'b0, rwe = 1'b0, bil = 1'b0, bir = 1'b0;
    logic [AW-1:0] la = '0, ra = '0;
    logic bl, br, lwo, rwo, lun, run;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dp_collision_arbiter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .master_mode(ms),
        .left_en(le), .left_addr(la), .left_we(lwe),
        .right_en(re), .right_addr(ra), .right_we(rwe),
        .busy_in_left(bil), .busy_in_right(bir),
        .busy_left_o(bl), .busy_right_o(br),
        .left_wr_ok(lwo), .right_wr_ok(rwo),
        .left_rd_unsure(lun), .right_rd_unsure(run)
    );

    typedef struct {
        logic  bl;
        logic  br;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // reference state: 0 none, 1 left, 2 right
    int m_owner = 0;
    logic p_le = 0, p_re = 0, p_bil = 0, p_bir = 0;
    logic [AW-1:0] p_la = '0, p_ra = '0;

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic l_en, input logic [AW-1:0] l_a,
                        input logic l_we, input logic r_en, input logic [AW-1:0] r_a,
                        input logic r_we, input logic b_l, input logic b_r,
                        input string tag);
        logic hit, lh, rh, blk_l, blk_r;
        int own;
        exp_t e;
        @(negedge clk);
        ms = m; le = l_en; la = l_a; lwe = l_we; re = r_en; ra = r_a; rwe = r_we;
        bil = b_l; bir = b_r;
        hit = l_en && r_en && (l_a == r_a);
        lh  = l_en && p_le && (l_a == p_la);
        rh  = r_en && p_re && (r_a == p_ra);
        if (!m || !hit) own = 0;
        else if (m_owner == 0) own = (rh && !lh) ? 2 : 1;
        else own = m_owner;
        blk_l = m ? (own == 2) : (b_l || p_bil);
        blk_r = m ? (own == 1) : (b_r || p_bir);
        #2;
        chk(lwo, l_en && l_we && !blk_l, {tag, " left_wr_ok"});
        chk(rwo, r_en && r_we && !blk_r, {tag, " right_wr_ok"});
        chk(lun, l_en && !l_we && blk_l, {tag, " left_rd_unsure"});
        chk(run, r_en && !r_we && blk_r, {tag, " right_rd_unsure"});
        e.bl = (own == 2); e.br = (own == 1); e.tag = tag;
        sb_q.push_back(e);
        m_owner = own;
        p_le = l_en; p_la = l_a; p_re = r_en; p_ra = r_a; p_bil = b_l; p_bir = b_r;
    endtask

    // monitor: registered busy appears after the edge following each step
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(bl, e.bl, {e.tag, " busy_left_o"});
                chk(br, e.br, {e.tag, " busy_right_o"});
            end
        end
    end

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bl, 1'b0, "R1 busy_left in reset");
        chk(br, 1'b0, "R1 busy_right in reset");
        rst_n = 1'b1;
        @(posedge clk); #3;
        chk(bl, 1'b0, "R1 busy_left after reset");
        chk(br, 1'b0, "R1 busy_right after reset");

        // R2: different addresses, then one side disabled
        step(1, 1, 14'h0005, 1, 1, 14'h0006, 1, 0, 0, "R2 diff addr");
        step(1, 1, 14'h0007, 1, 0, 14'h0007, 1, 0, 0, "R2 right off");
        // R3 / R7: left in place first, right arrives writing
        step(1, 1, 14'h0100, 1, 0, 14'h0000, 0, 0, 0, "R3 left settle");
        step(1, 1, 14'h0100, 0, 1, 14'h0100, 1, 0, 0, "R3 R7 right late");
        // R5 / R8: collision held; right reads as loser
        step(1, 1, 14'h0100, 0, 1, 14'h0100, 1, 0, 0, "R5 hold 1");
        step(1, 1, 14'h0100, 1, 1, 14'h0100, 0, 0, 0, "R5 R8 hold 2");
        // R6: address mismatch clears
        step(1, 1, 14'h0100, 1, 1, 14'h0101, 0, 0, 0, "R6 mismatch");
        // R3: right in place first, left arrives
        step(1, 0, 14'h0000, 0, 1, 14'h0200, 1, 0, 0, "R3 right settle");
        step(1, 1, 14'h0200, 1, 1, 14'h0200, 1, 0, 0, "R3 R7 left late");
        step(1, 1, 14'h0200, 0, 1, 14'h0200, 1, 0, 0, "R8 R5 left reads");
        // R6: enable drop clears
        step(1, 0, 14'h0200, 0, 1, 14'h0200, 1, 0, 0, "R6 enable drop");
        // R4: both arrive same cycle
        step(1, 1, 14'h0010, 0, 1, 14'h0020, 0, 0, 0, "R4 apart");
        step(1, 1, 14'h3FFF, 1, 1, 14'h3FFF, 1, 0, 0, "R4 tie");
        step(1, 1, 14'h3FFF, 1, 1, 14'h3FFF, 1, 0, 0, "R4 R5 tie hold");
        step(1, 0, 14'h0000, 0, 0, 14'h0000, 0, 0, 0, "R6 idle");
        // R9 / R10: following mode
        step(0, 1, 14'h0300, 1, 1, 14'h0300, 1, 1, 0, "R9 R10 busy in");
        step(0, 1, 14'h0300, 1, 1, 14'h0300, 1, 0, 0, "R9 settle");
        step(0, 1, 14'h0300, 1, 1, 14'h0300, 1, 0, 0, "R9 R10 released");
        step(0, 1, 14'h0300, 1, 1, 14'h0300, 0, 0, 1, "R9 right busy read");
        step(0, 0, 14'h0000, 0, 0, 14'h0000, 0, 0, 0, "R10 slave idle");
        // R10: deciding mode ignores busy inputs
        step(1, 1, 14'h0400, 1, 1, 14'h0401, 1, 1, 1, "R10 master ignores in");
        step(1, 0, 14'h0000, 0, 0, 14'h0000, 0, 0, 0, "R11 end");
        repeat (3) @(posedge clk);
        #5;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule